// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block turns a single host request into the complete write-strobe sequence that an 8-bit parallel NOR flash needs for a byte program, a sector erase or a chip erase. Once the command has been written, it polls the device until the operation is complete. The host pulses `start_i` with an operation code, a target address and a data byte. The block raises `busy_o` and drives every flash write cycle itself. Each write cycle has a setup clock and a write-enable low pulse of `WE_LOW` clocks. After the last write it reads the target location repeatedly with output-enable, and checks only data bit 7. When the completion rule for that operation holds, it gives a one-clock `done_o` pulse. If the rule still fails after `MAX_POLLS` reads, it gives a one-clock `timeout_o` pulse instead.

The controller is a state machine with six states:
- `S_IDLE` waits for an accepted start. An accepted start moves it to `S_SETUP`.
- `S_SETUP` puts the address and data for the current step on the bus, with chip-select low and write-enable high. It always moves to `S_PULSE`.
- `S_PULSE` holds write-enable low until the strobe timer expires. On expiry it moves back to `S_SETUP` with the next step, or to `S_PGAP` after the final step.
- `S_PGAP` is one clock with all strobes high. It always moves to `S_PRD`.
- `S_PRD` drives chip-select and output-enable low. It always moves to `S_PSMP`.
- `S_PSMP` keeps the read asserted and samples bit 7 at the end of its clock. From there it moves to `S_IDLE` with done, to `S_IDLE` with timeout, or back to `S_PGAP` for another read.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `timeout_o` are 0. `fl_ce_n_o`, `fl_oe_n_o` and `fl_we_n_o` are 1, and `fl_dq_oe_o` is 0.
- R2: Operation code 2'b00 (byte program) produces exactly four writes, given as address/data: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then target address/target data.
- R3: Operation code 2'b01 (sector erase) produces exactly six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then target (sector) address/30h.
- R4: Operation code 2'b10 (chip erase) produces the same six writes as R3, except that the last one is 5555h/10h.
- R5: Each write has the following timing:
  - Address and data are on the bus one clock before write-enable falls, and they stay unchanged until it rises.
  - Write-enable stays low for exactly `WE_LOW` clocks.
  - Write-enable is high for exactly one clock between consecutive writes of a command.
  - Chip-select is low and output-enable is high throughout each write.
- R6: For a program, completion is the first poll read whose bit 7 equals bit 7 of the programmed data.
- R7: For either erase, completion is the first poll read whose bit 7 is 1.
- R8: `done_o` is a single-clock pulse, and `busy_o` is already 0 in that clock.
- R9: If `MAX_POLLS` consecutive reads all fail the completion rule, `timeout_o` pulses for one clock. `done_o` stays 0, and the block returns to idle.
- R10: `start_i` is ignored while `busy_o` is 1. The running command keeps its operation, address and data.
- R11: A start with the reserved operation code 2'b11 is ignored. `busy_o` stays 0 and no write is issued.
- R12: Every poll read drives the target address with chip-select and output-enable low, write-enable high and the data bus released. Each read ends with output-enable rising for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| op_i | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| addr_i | input | ADDR_W | Target address (program location or sector) |
| data_i | input | 8 | Byte to program |
| busy_o | output | 1 | Command or polling in progress |
| done_o | output | 1 | One-clock completion pulse |
| timeout_o | output | 1 | One-clock poll-limit pulse |
| fl_addr_o | output | ADDR_W | Flash address bus |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_oe_o | output | 1 | Data bus output enable (1 = block drives) |
| fl_q7_i | input | 1 | Flash read data bit 7 |
| fl_ce_n_o | output | 1 | Chip select, active low |
| fl_oe_n_o | output | 1 | Output enable, active low |
| fl_we_n_o | output | 1 | Write enable, active low |

## Verification
The bench aims at the step where the sequences split: the third and sixth command bytes, and the fourth write that is the target write only for program. A design that swapped these bytes would show the wrong data in the captured write list. The completion polarity is checked with a program byte whose bit 7 is 0 and with erases that finish on a 1. A design that used the erase rule for program would finish on the first read. The poll limit is checked at both sides of its boundary: completion on the last permitted read must give done, and one more busy read must give timeout. An off-by-one counter would flip one of those two results. A start during a running command and a start with the reserved code must leave the issued writes untouched. A design that accepted either would issue extra writes or change the target.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_NONE = 2'b11
    } fcs_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_PULSE,
        S_PGAP,
        S_PRD,
        S_PSMP
    } fcs_state_e;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE  = 8'h80;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECT   = 8'h30;

    // index of the final write step for an operation
    function automatic logic [2:0] final_step(input fcs_op_e op);
        return (op == OP_PROG) ? 3'd3 : 3'd5;
    endfunction

endpackage

// File: rtl/fcs_step_rom.sv
module fcs_step_rom
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  fcs_op_e             op_i,
    input  logic [2:0]          step_i,
    input  logic [ADDR_W-1:0]   tgt_addr_i,
    input  logic [7:0]          tgt_data_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [7:0]          data_o
);

    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADDR_B);

    always_comb begin
        addr_o = ADR_A;
        data_o = KEY_DATA_A;
        unique case (step_i)
            3'd0: begin
                addr_o = ADR_A;
                data_o = KEY_DATA_A;
            end
            3'd1, 3'd4: begin
                addr_o = ADR_B;
                data_o = KEY_DATA_B;
            end
            3'd2: begin
                addr_o = ADR_A;
                data_o = (op_i == OP_PROG) ? CMD_PROG : CMD_ERASE;
            end
            3'd3: begin
                // program: target write; erase: second unlock starts
                addr_o = (op_i == OP_PROG) ? tgt_addr_i : ADR_A;
                data_o = (op_i == OP_PROG) ? tgt_data_i : KEY_DATA_A;
            end
            3'd5: begin
                addr_o = (op_i == OP_CHIP) ? ADR_A : tgt_addr_i;
                data_o = (op_i == OP_CHIP) ? CMD_CHIP : CMD_SECT;
            end
            default: begin
                addr_o = ADR_A;
                data_o = KEY_DATA_A;
            end
        endcase
    end

endmodule

// File: rtl/fcs_strobe_timer.sv
module fcs_strobe_timer #(
    parameter int WE_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);

    localparam int CW = (WE_LOW > 1) ? $clog2(WE_LOW) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(WE_LOW - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (!run_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = run_i && (cnt_q == '0);

    // R5: a pulse never outlasts its configured width
    a_r5_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !expire_o |=> cnt_q < $past(cnt_q) || !run_i);

endmodule

// File: rtl/fcs_poll_judge.sv
module fcs_poll_judge #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic sample_i,
    input  logic is_prog_i,
    input  logic want7_i,
    input  logic rd7_i,
    output logic complete_o,
    output logic exhausted_o
);

    localparam int PW = $clog2(MAX_POLLS) + 1;
    localparam logic [PW-1:0] LAST = PW'(MAX_POLLS - 1);

    logic [PW-1:0] cnt_q;
    logic          rule_met;

    // program ends when bit 7 matches; erase ends when bit 7 reads 1
    assign rule_met    = is_prog_i ? (rd7_i == want7_i) : rd7_i;
    assign complete_o  = sample_i && rule_met;
    assign exhausted_o = sample_i && !rule_met && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (sample_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the read counter never passes the limit
    a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int WE_LOW    = 2,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_dq_o,
    output logic              fl_dq_oe_o,
    input  logic              fl_q7_i,
    output logic              fl_ce_n_o,
    output logic              fl_oe_n_o,
    output logic              fl_we_n_o
);

    fcs_state_e        state_q, state_d;
    fcs_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [2:0]        step_q;
    logic              done_q, tmo_q;

    logic              accept, pulse_end, last_step;
    logic              complete, exhausted;
    logic [ADDR_W-1:0] rom_addr;
    logic [7:0]        rom_data;

    assign accept    = (state_q == S_IDLE) && start_i && (fcs_op_e'(op_i) != OP_NONE);
    assign last_step = (step_q == final_step(op_q));

    fcs_step_rom #(.ADDR_W(ADDR_W)) u_rom (
        .op_i       (op_q),
        .step_i     (step_q),
        .tgt_addr_i (addr_q),
        .tgt_data_i (data_q),
        .addr_o     (rom_addr),
        .data_o     (rom_data)
    );

    fcs_strobe_timer #(.WE_LOW(WE_LOW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state_q == S_PULSE),
        .expire_o (pulse_end)
    );

    fcs_poll_judge #(.MAX_POLLS(MAX_POLLS)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .sample_i    (state_q == S_PSMP),
        .is_prog_i   (op_q == OP_PROG),
        .want7_i     (data_q[7]),
        .rd7_i       (fl_q7_i),
        .complete_o  (complete),
        .exhausted_o (exhausted)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_SETUP;
            S_SETUP: state_d = S_PULSE;
            S_PULSE: if (pulse_end) state_d = last_step ? S_PGAP : S_SETUP;
            S_PGAP:  state_d = S_PRD;
            S_PRD:   state_d = S_PSMP;
            S_PSMP:  state_d = (complete || exhausted) ? S_IDLE : S_PGAP;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            step_q  <= '0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_PSMP) && complete;
            tmo_q   <= (state_q == S_PSMP) && exhausted;
            if (accept) begin
                op_q   <= fcs_op_e'(op_i);
                addr_q <= addr_i;
                data_q <= data_i;
                step_q <= '0;
            end else if (state_q == S_PULSE && pulse_end && !last_step) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        fl_addr_o  = '0;
        fl_dq_o    = '0;
        fl_dq_oe_o = 1'b0;
        fl_ce_n_o  = 1'b1;
        fl_oe_n_o  = 1'b1;
        fl_we_n_o  = 1'b1;
        unique case (state_q)
            S_IDLE: ;
            S_SETUP, S_PULSE: begin
                fl_addr_o  = rom_addr;
                fl_dq_o    = rom_data;
                fl_dq_oe_o = 1'b1;
                fl_ce_n_o  = 1'b0;
                fl_we_n_o  = (state_q == S_SETUP);
            end
            S_PGAP: fl_addr_o = addr_q;
            S_PRD, S_PSMP: begin
                fl_addr_o = addr_q;
                fl_ce_n_o = 1'b0;
                fl_oe_n_o = 1'b0;
            end
            default: ;
        endcase
    end

    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = done_q;
    assign timeout_o = tmo_q;

    // R5: write strobe only with chip selected, read disabled, bus driven
    a_r5_write_context: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n_o |-> !fl_ce_n_o && fl_oe_n_o && fl_dq_oe_o);

    // R5: address and data unchanged from setup through the whole low pulse
    a_r5_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n_o |-> $stable(fl_addr_o) && $stable(fl_dq_o));

    // R12: poll read never drives the data bus nor strobes a write
    a_r12_read_context: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n_o |-> !fl_dq_oe_o && fl_we_n_o && !fl_ce_n_o);

    // R8: done lasts one clock and busy has already dropped
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9: timeout and done never coincide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    // R10: a request while busy leaves the command context untouched
    a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(addr_q) && $stable(op_q) && $stable(data_q));

    // R11: reserved code does not start anything
    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i && op_i == 2'b11 |=> !busy_o);

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 20;
    localparam int WE_LOW     = 3;
    localparam int MAX_POLLS  = 6;
    localparam int NVEC       = 7;

    // {op[38:37], addr[36:17], data[16:9], busy_reads[8:1], expect_timeout[0]}
    localparam logic [38:0] VEC [NVEC] = '{
        {2'b00, 20'h12345, 8'hC3, 8'd2, 1'b0},
        {2'b00, 20'hFFFFF, 8'h3C, 8'd0, 1'b0},
        {2'b01, 20'h40000, 8'h00, 8'd3, 1'b0},
        {2'b10, 20'h00000, 8'h00, 8'd1, 1'b0},
        {2'b00, 20'h0ABCD, 8'h80, 8'd5, 1'b0},
        {2'b00, 20'h00ABC, 8'h80, 8'd6, 1'b1},
        {2'b01, 20'h7A000, 8'h00, 8'd9, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    op_i = 2'b00;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic          busy_o, done_o, timeout_o;
    logic [AW-1:0] fl_addr_o;
    logic [7:0]    fl_dq_o;
    logic          fl_dq_oe_o, fl_q7_i, fl_ce_n_o, fl_oe_n_o, fl_we_n_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .WE_LOW(WE_LOW), .MAX_POLLS(MAX_POLLS)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .addr_i(addr_i), .data_i(data_i), .busy_o(busy_o), .done_o(done_o),
        .timeout_o(timeout_o), .fl_addr_o(fl_addr_o), .fl_dq_o(fl_dq_o),
        .fl_dq_oe_o(fl_dq_oe_o), .fl_q7_i(fl_q7_i), .fl_ce_n_o(fl_ce_n_o),
        .fl_oe_n_o(fl_oe_n_o), .fl_we_n_o(fl_we_n_o)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [1:0]    m_op = 2'b00;
    logic [7:0]    m_data = 8'h00;
    logic [AW-1:0] m_addr = '0;
    int            polls_left = 0;
    int            poll_n = 0;
    bit            poll_bad = 0;

    assign fl_q7_i = (!fl_oe_n_o && !fl_ce_n_o) ?
                     ((polls_left > 0) ? ((m_op == 2'b00) ? ~m_data[7] : 1'b0)
                                       : ((m_op == 2'b00) ?  m_data[7] : 1'b1))
                     : 1'b0;

    always @(negedge fl_oe_n_o) begin
        if (fl_addr_o !== m_addr || fl_we_n_o !== 1'b1 || fl_dq_oe_o !== 1'b0) poll_bad = 1;
    end
    always @(posedge fl_oe_n_o) begin
        if (rst_n) begin
            poll_n++;
            if (polls_left > 0) polls_left--;
        end
    end

    // ---------------- write monitor ----------------
    logic [AW-1:0] wr_a [8];
    logic [7:0]    wr_d [8];
    int            wr_cnt = 0;
    bit            timing_bad = 0;
    logic          prev_we = 1'b1;
    logic [AW-1:0] prev_a = '0, cur_a = '0;
    logic [7:0]    prev_d = '0, cur_d = '0;
    int            low_n = 0, gap_n = 0;

    always @(negedge clk) begin
        if (fl_we_n_o === 1'b0) begin
            if (prev_we) begin
                cur_a = fl_addr_o;
                cur_d = fl_dq_o;
                low_n = 1;
                if (fl_addr_o !== prev_a || fl_dq_o !== prev_d) timing_bad = 1;
                if (wr_cnt > 0 && gap_n != 1) timing_bad = 1;
            end else begin
                low_n++;
                if (fl_addr_o !== cur_a || fl_dq_o !== cur_d) timing_bad = 1;
            end
            if (fl_ce_n_o !== 1'b0 || fl_oe_n_o !== 1'b1) timing_bad = 1;
        end else begin
            if (!prev_we) begin
                if (wr_cnt < 8) begin
                    wr_a[wr_cnt] = cur_a;
                    wr_d[wr_cnt] = cur_d;
                end
                if (low_n != WE_LOW) timing_bad = 1;
                wr_cnt++;
                gap_n = 0;
            end
            gap_n++;
        end
        prev_we = fl_we_n_o;
        prev_a  = fl_addr_o;
        prev_d  = fl_dq_o;
    end

    // ---------------- expected sequences (R2, R3, R4) ----------------
    function automatic logic [AW-1:0] exp_a(input logic [1:0] op, input int k, input logic [AW-1:0] t);
        case (k)
            0, 2: return AW'(16'h5555);
            1, 4: return AW'(16'h2AAA);
            3:    return (op == 2'b00) ? t : AW'(16'h5555);
            default: return (op == 2'b10) ? AW'(16'h5555) : t;
        endcase
    endfunction

    function automatic logic [7:0] exp_d(input logic [1:0] op, input int k, input logic [7:0] d);
        case (k)
            0:    return 8'hAA;
            1, 4: return 8'h55;
            2:    return (op == 2'b00) ? 8'hA0 : 8'h80;
            3:    return (op == 2'b00) ? d : 8'hAA;
            default: return (op == 2'b10) ? 8'h10 : 8'h30;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] op);
        return (op == 2'b00) ? "R2" : (op == 2'b01) ? "R3" : "R4";
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                          input int busy_reads, input bit exp_to, input bit inject);
        int cyc;
        int nwr;
        bit seq_ok;
        @(posedge clk);
        wr_cnt = 0; timing_bad = 0; poll_n = 0; poll_bad = 0;
        m_op = op; m_data = d; m_addr = a; polls_left = busy_reads;
        @(negedge clk);
        start_i = 1'b1; op_i = op; addr_i = a; data_i = d;
        @(negedge clk);
        start_i = 1'b0;
        if (inject) begin
            repeat (4) @(negedge clk);
            // R10: request during a running command
            start_i = 1'b1; op_i = 2'b01; addr_i = 20'h22222; data_i = 8'h11;
            @(negedge clk);
            start_i = 1'b0;
        end
        cyc = 0;
        while (!(done_o || timeout_o) && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        nwr = (op == 2'b00) ? 4 : 6;
        chk(wr_cnt == nwr, req_of(op), "write count", wr_cnt, nwr);
        seq_ok = 1;
        for (int k = 0; k < nwr && k < 8; k++)
            if (wr_a[k] !== exp_a(op, k, a) || wr_d[k] !== exp_d(op, k, d)) begin
                seq_ok = 0;
                chk(0, req_of(op), $sformatf("write %0d addr/data", k),
                    {4'h0, wr_a[k], wr_d[k]}, {4'h0, exp_a(op, k, a), exp_d(op, k, d)});
            end
        if (seq_ok) chk(1, req_of(op), "sequence", 0, 0);
        chk(!timing_bad, "R5", "write strobe timing", timing_bad, 0);
        chk(!poll_bad, "R12", "poll read bus state", poll_bad, 0);
        if (exp_to) begin
            chk(timeout_o && !done_o, "R9", "timeout flag", {timeout_o, done_o}, 2'b10);
            chk(poll_n == MAX_POLLS, "R9", "reads before timeout", poll_n, MAX_POLLS);
        end else begin
            chk(done_o && !timeout_o, (op == 2'b00) ? "R6" : "R7", "done flag",
                {timeout_o, done_o}, 2'b01);
            chk(poll_n == busy_reads + 1, (op == 2'b00) ? "R6" : "R7", "reads to completion",
                poll_n, busy_reads + 1);
        end
        chk(!busy_o, "R8", "busy low with result pulse", busy_o, 0);
        @(negedge clk);
        chk(!done_o && !timeout_o && !busy_o, "R8", "pulse one clock wide",
            {busy_o, timeout_o, done_o}, 0);
    endtask

    // ---------------- watchdog ----------------
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o && !timeout_o, "R1", "status at reset",
            {busy_o, done_o, timeout_o}, 0);
        chk(fl_ce_n_o && fl_oe_n_o && fl_we_n_o && !fl_dq_oe_o, "R1", "strobes at reset",
            {fl_ce_n_o, fl_oe_n_o, fl_we_n_o, fl_dq_oe_o}, 4'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && fl_we_n_o, "R1", "idle after release", {busy_o, fl_we_n_o}, 2'b01);

        for (int i = 0; i < NVEC; i++)
            run_op(VEC[i][38:37], VEC[i][36:17], VEC[i][16:9], int'(VEC[i][8:1]), VEC[i][0], 1'b0);

        // R10: start while busy is dropped
        run_op(2'b00, 20'h01111, 8'h55, 3, 1'b0, 1'b1);
        chk(wr_a[3] == 20'h01111 && wr_d[3] == 8'h55, "R10", "target kept",
            {4'h0, wr_a[3], wr_d[3]}, {4'h0, 20'h01111, 8'h55});

        // R11: reserved op code
        @(posedge clk);
        wr_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; op_i = 2'b11; addr_i = 20'h33333; data_i = 8'h99;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy_o && wr_cnt == 0 && fl_we_n_o, "R11", "reserved code ignored",
            {busy_o, wr_cnt[7:0]}, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule